// File: doc/BRIEF.md
# SDRAM Command Protocol Checker

This block is a passive monitor for the command pins of a four-bank synchronous DRAM. On every rising clock edge it decodes the sampled chip-select, row-strobe, column-strobe and write-enable pins into one command. It keeps a model of each bank: idle, open with a row, or in a burst that will close the bank by itself when it ends (auto-precharge). It also counts the cycles since the last activate, since each bank began to close, and since the last refresh.

When a command breaks a bank-state rule or a minimum gap, the checker raises one bit of a registered error vector for one cycle. It also gives a code for the highest-priority error in that cycle. Each error bit is also held in a sticky vector until a clear pulse. The minimum gaps, the burst length and the refresh budget are inputs, so one instance can serve several speed grades.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With `cs_ni` low, `{ras_ni,cas_ni,we_ni}` decodes as 000 mode-set, 001 refresh, 011 activate, 101 read, 100 write, 110 burst stop, 010 precharge, 111 no-op. With `cs_ni` high, all other command, bank and address inputs are ignored and no bank changes state.
- R2: A mode-set or refresh issued while any bank is open or in an auto-precharge burst raises flag 1 (code 2).
- R3: Any command other than no-op in either of the two cycles after a mode-set raises flag 0 (code 1).
- R4: A read or write with `addr_i[10]` high opens an auto-precharge burst of BL cycles. A read or write to any bank in the BL-1 cycles after that command raises flag 2 (code 3). From cycle BL after the command, such reads and writes are legal.
- R5: An activate to a bank issued fewer than `cfg_trp_i` cycles after that bank began to close raises flag 7 (code 8). A bank begins to close on a precharge or a burst stop that ends its auto-precharge burst, or, for an auto-precharge burst, in cycle BL after the column command.
- R6: A precharge with `addr_i[10]` high closes every bank whatever `bank_i` holds, and is never flagged. Column commands one cycle apart to an open bank are legal.
- R7: A read or write fewer than `cfg_trcd_i` cycles after its bank's activate raises flag 4 (code 5). An activate fewer than `cfg_trrd_i` cycles after an activate of another bank raises flag 5 (code 6). An activate fewer than `cfg_trc_i` cycles after the same bank's previous activate raises flag 6 (code 7).
- R8: A burst stop is never flagged by a command rule, at any burst length. It ends any auto-precharge burst in progress.
- R9: A read, a write or a single-bank precharge (`addr_i[10]` low) to an idle bank, or an activate to a bank that is not idle, raises flag 3 (code 4).
- R10: When the cycles since the last refresh (or since reset) reach `cfg_refi_i + cfg_ref_slack_i + 1`, flag 8 (code 9) is raised once.
- R11: Flags appear in the cycle after the offending command. `err_code_o` is one plus the lowest set flag index, or 0 when no flag is set. `err_sticky_o` collects the flags, and `clear_i` empties it. All outputs are zero after reset.
- R12: `cfg_bl_i` selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. With length 1 there is no window in which column commands are forbidden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| bank_i | input | 2 | Bank address |
| addr_i | input | 12 | Multiplexed address; bit 10 selects auto-precharge or all banks |
| cfg_trcd_i | input | 6 | Minimum activate-to-column gap, in cycles |
| cfg_trp_i | input | 6 | Minimum close-to-activate gap, in cycles |
| cfg_trrd_i | input | 6 | Minimum gap between activates of different banks |
| cfg_trc_i | input | 6 | Minimum gap between activates of the same bank |
| cfg_bl_i | input | 2 | Burst length select |
| cfg_refi_i | input | 16 | Average refresh interval, in cycles |
| cfg_ref_slack_i | input | 16 | Allowed overrun of the refresh interval |
| clear_i | input | 1 | Clears the sticky error vector |
| err_flags_o | output | 9 | Per-rule error pulses |
| err_code_o | output | 4 | Code of the highest-priority error this cycle |
| err_sticky_o | output | 9 | Accumulated error bits |

## Verification
The assertions assume that the configuration inputs do not change while an auto-precharge burst is running. They also assume that the refresh budget is not so small that a refresh in every cycle is still late. The stimulus changes the burst length only while no bank is in a burst, and it keeps the refresh budget far above any gap it creates. Each command is driven half a cycle before the edge that samples it. A behavioural bank model in the bench predicts every flag, the error code and the sticky vector, and compares them after every edge.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_REF, CMD_ACT, CMD_RD, CMD_WR, CMD_BST, CMD_PRE
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE, BK_ACTIVE, BK_APB
  } bank_st_e;

  // flag index; code = index + 1, lower index wins
  localparam int ERR_QUIET    = 0;
  localparam int ERR_NOT_IDLE = 1;
  localparam int ERR_AP_COL   = 2;
  localparam int ERR_BANK_ST  = 3;
  localparam int ERR_TRCD     = 4;
  localparam int ERR_TRRD     = 5;
  localparam int ERR_TRC      = 6;
  localparam int ERR_TRP      = 7;
  localparam int ERR_REF_LATE = 8;
  localparam int NUM_ERR      = 9;
  localparam int ERR_CODE_W   = $clog2(NUM_ERR + 1);

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);

  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b110:  cmd_o = CMD_BST;
        3'b010:  cmd_o = CMD_PRE;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_chk_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int BLV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             col_ap_i,
  input  logic             pre_i,
  input  logic             bst_i,
  input  logic [BLV_W-1:0] bl_i,
  output bank_st_e         state_o,
  output logic [CNT_W-1:0] act_cnt_o,
  output logic [CNT_W-1:0] trp_cnt_o
);

  bank_st_e         state_q;
  logic [BLV_W-1:0] rem_q;
  logic [CNT_W-1:0] act_cnt_q, trp_cnt_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= BK_IDLE;
      rem_q     <= '0;
      act_cnt_q <= '1;
      trp_cnt_q <= '1;
    end else begin
      act_cnt_q <= act_i ? CNT_W'(1) : sat_inc(act_cnt_q);
      if (act_i) begin
        state_q   <= BK_ACTIVE;
        trp_cnt_q <= sat_inc(trp_cnt_q);
      end else if (pre_i && state_q != BK_IDLE) begin
        state_q   <= BK_IDLE;
        trp_cnt_q <= CNT_W'(1);
      end else if (bst_i && state_q == BK_APB) begin
        state_q   <= BK_IDLE;
        trp_cnt_q <= CNT_W'(1);
      end else if (col_ap_i) begin
        if (bl_i == BLV_W'(1)) begin
          state_q   <= BK_IDLE;
          trp_cnt_q <= '0;
        end else begin
          state_q   <= BK_APB;
          rem_q     <= bl_i - BLV_W'(2);
          trp_cnt_q <= sat_inc(trp_cnt_q);
        end
      end else if (state_q == BK_APB) begin
        if (rem_q == '0) begin
          state_q   <= BK_IDLE;
          trp_cnt_q <= '0;   // implicit close starts the cycle after the last beat
        end else begin
          rem_q     <= rem_q - 1'b1;
          trp_cnt_q <= sat_inc(trp_cnt_q);
        end
      end else begin
        trp_cnt_q <= sat_inc(trp_cnt_q);
      end
    end
  end

  assign state_o   = state_q;
  assign act_cnt_o = act_cnt_q;
  assign trp_cnt_o = trp_cnt_q;

  // an idle bank never jumps straight into an auto-precharge burst
  assert_apb_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BK_IDLE) |=> (state_q != BK_APB));

endmodule

// File: rtl/sdram_refresh_mon.sv
module sdram_refresh_mon #(
  parameter int REF_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [REF_W-1:0] refi_i,
  input  logic [REF_W-1:0] slack_i,
  output logic             late_o
);

  localparam int CW = REF_W + 2;

  logic [CW-1:0] cnt_q, target;

  assign target = CW'(refi_i) + CW'(slack_i) + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ref_i) cnt_q <= CW'(1);
    else if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign late_o = (cnt_q == target);

  assert_late_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_o && !ref_i) |=> !late_o);

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int CNT_W     = 6,
  parameter int REF_W     = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  ras_ni,
  input  logic                  cas_ni,
  input  logic                  we_ni,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      cfg_trcd_i,
  input  logic [CNT_W-1:0]      cfg_trp_i,
  input  logic [CNT_W-1:0]      cfg_trrd_i,
  input  logic [CNT_W-1:0]      cfg_trc_i,
  input  logic [1:0]            cfg_bl_i,
  input  logic [REF_W-1:0]      cfg_refi_i,
  input  logic [REF_W-1:0]      cfg_ref_slack_i,
  input  logic                  clear_i,
  output logic [NUM_ERR-1:0]    err_flags_o,
  output logic [ERR_CODE_W-1:0] err_code_o,
  output logic [NUM_ERR-1:0]    err_sticky_o
);

  localparam int BLV_W = 4;

  cmd_e             cmd;
  bank_st_e         bank_st [NUM_BANKS];
  logic [CNT_W-1:0] act_cnt [NUM_BANKS];
  logic [CNT_W-1:0] trp_cnt [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_v, apb_v, rrd_short;
  logic [BLV_W-1:0] bl_val;
  logic             is_col, ap, late;
  logic [1:0]       quiet_q;
  logic [NUM_ERR-1:0]    err_next;
  logic [ERR_CODE_W-1:0] code_next;
  logic             unused_addr;

  sdram_cmd_decode u_dec (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  assign is_col      = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign ap          = addr_i[AP_BIT];
  assign bl_val      = BLV_W'(1) << cfg_bl_i;
  assign unused_addr = ^addr_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));

    sdram_bank_track #(.CNT_W(CNT_W), .BLV_W(BLV_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (cmd == CMD_ACT && sel),
      .col_ap_i (is_col && sel && ap && bank_st[b] == BK_ACTIVE),
      .pre_i    (cmd == CMD_PRE && (ap || sel)),
      .bst_i    (cmd == CMD_BST),
      .bl_i     (bl_val),
      .state_o  (bank_st[b]),
      .act_cnt_o(act_cnt[b]),
      .trp_cnt_o(trp_cnt[b])
    );

    assign open_v[b]    = (bank_st[b] != BK_IDLE);
    assign apb_v[b]     = (bank_st[b] == BK_APB);
    assign rrd_short[b] = (act_cnt[b] < cfg_trrd_i);
  end

  sdram_refresh_mon #(.REF_W(REF_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (cmd == CMD_REF),
    .refi_i (cfg_refi_i),
    .slack_i(cfg_ref_slack_i),
    .late_o (late)
  );

  bank_st_e         cur_st;
  logic [CNT_W-1:0] cur_act, cur_trp;
  logic             other_rrd, act_ok;

  assign cur_st    = bank_st[bank_i];
  assign cur_act   = act_cnt[bank_i];
  assign cur_trp   = trp_cnt[bank_i];
  assign other_rrd = |(rrd_short & ~(NUM_BANKS'(1) << bank_i));
  assign act_ok    = (cmd == CMD_ACT) && (cur_st == BK_IDLE);

  always_comb begin
    err_next = '0;
    err_next[ERR_QUIET]    = (quiet_q != '0) && (cmd != CMD_NOP);
    err_next[ERR_NOT_IDLE] = ((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|open_v);
    err_next[ERR_AP_COL]   = is_col && (|apb_v);
    err_next[ERR_BANK_ST]  = (is_col && cur_st == BK_IDLE)
                          || (cmd == CMD_PRE && !ap && cur_st == BK_IDLE)
                          || (cmd == CMD_ACT && cur_st != BK_IDLE);
    err_next[ERR_TRCD]     = is_col && (cur_st == BK_ACTIVE) && (cur_act < cfg_trcd_i);
    err_next[ERR_TRRD]     = act_ok && other_rrd;
    err_next[ERR_TRC]      = act_ok && (cur_act < cfg_trc_i);
    err_next[ERR_TRP]      = act_ok && (cur_trp < cfg_trp_i);
    err_next[ERR_REF_LATE] = late;
  end

  always_comb begin
    code_next = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (err_next[i]) code_next = ERR_CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q      <= '0;
      err_flags_o  <= '0;
      err_code_o   <= '0;
      err_sticky_o <= '0;
    end else begin
      if (cmd == CMD_MRS)      quiet_q <= 2'd2;
      else if (quiet_q != '0)  quiet_q <= quiet_q - 1'b1;
      err_flags_o  <= err_next;
      err_code_o   <= code_next;
      err_sticky_o <= (clear_i ? '0 : err_sticky_o) | err_next;
    end
  end

  assert_mrs_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd == CMD_MRS || cmd == CMD_REF) && (|open_v)) |=> err_flags_o[ERR_NOT_IDLE]);

  assert_code_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code_o == '0) == (err_flags_o == '0));

  assert_sticky_cover_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flags_o & ~err_sticky_o) == '0);

  assert_bst_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_BST && quiet_q == '0) |=> (err_flags_o[ERR_REF_LATE-1:0] == '0));

endmodule

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_MRS = 4'b0000;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_BST = 4'b0110;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam int AP    = 1 << 10;
  localparam int TRCD  = 3, TRP = 3, TRRD = 2, TRC = 7;
  localparam int REFI  = 400, SLACK = 50;
  localparam int LIMIT = REFI + SLACK + 1;
  localparam int SAT   = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pins = P_NOP;
  logic [1:0] bank = '0;
  logic [11:0] addr = '0;
  logic [1:0] cfg_bl = 2'd2;
  logic clr = 1'b0;
  logic [8:0] flags, sticky;
  logic [3:0] code;

  always #5 clk = ~clk;

  sdram_cmd_checker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cs_ni(pins[3]), .ras_ni(pins[2]), .cas_ni(pins[1]), .we_ni(pins[0]),
    .bank_i(bank), .addr_i(addr),
    .cfg_trcd_i(6'(TRCD)), .cfg_trp_i(6'(TRP)), .cfg_trrd_i(6'(TRRD)), .cfg_trc_i(6'(TRC)),
    .cfg_bl_i(cfg_bl), .cfg_refi_i(16'(REFI)), .cfg_ref_slack_i(16'(SLACK)),
    .clear_i(clr), .err_flags_o(flags), .err_code_o(code), .err_sticky_o(sticky)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input int actv, input int expv, input string rq, input string what);
    n_chk++;
    if (actv != expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, actv, expv);
    end
  endtask

  // behavioural reference: 0 idle, 1 open, 2 auto-precharge burst
  int m_st[4], m_rem[4], m_act[4], m_trp[4];
  int m_quiet, m_ref;
  logic [8:0] e_flags, e_sticky;
  int e_code;

  function automatic int sat(input int v);
    return (v < SAT) ? v + 1 : SAT;
  endfunction

  function automatic int dec(input logic [3:0] p);
    if (p[3]) return 0;
    case (p[2:0])
      3'b000: return 1;
      3'b001: return 2;
      3'b011: return 3;
      3'b101: return 4;
      3'b100: return 5;
      3'b110: return 6;
      3'b010: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic string rq_of(input int i);
    case (i)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      3: return "R9";
      7: return "R5";
      8: return "R10";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin
        m_st[b] = 0; m_rem[b] = 0; m_act[b] = SAT; m_trp[b] = SAT;
      end
      m_quiet = 0; m_ref = 0; e_flags = '0; e_sticky = '0; e_code = 0;
    end else begin
      int c, bk, blv;
      bit ap, any_open, any_apb, col;
      logic [8:0] e;
      c = dec(pins); bk = int'(bank); ap = addr[10]; e = '0;
      col = (c == 4) || (c == 5);
      any_open = 1'b0; any_apb = 1'b0;
      for (int b = 0; b < 4; b++) begin
        if (m_st[b] != 0) any_open = 1'b1;
        if (m_st[b] == 2) any_apb = 1'b1;
      end
      if (m_quiet > 0 && c != 0) e[0] = 1'b1;
      if ((c == 1 || c == 2) && any_open) e[1] = 1'b1;
      if (col && any_apb) e[2] = 1'b1;
      if ((col && m_st[bk] == 0) || (c == 7 && !ap && m_st[bk] == 0) || (c == 3 && m_st[bk] != 0))
        e[3] = 1'b1;
      if (col && m_st[bk] == 1 && m_act[bk] < TRCD) e[4] = 1'b1;
      if (c == 3 && m_st[bk] == 0) begin
        for (int o = 0; o < 4; o++) if (o != bk && m_act[o] < TRRD) e[5] = 1'b1;
        if (m_act[bk] < TRC) e[6] = 1'b1;
        if (m_trp[bk] < TRP) e[7] = 1'b1;
      end
      if (m_ref == LIMIT) e[8] = 1'b1;
      blv = 1 << cfg_bl;
      for (int b = 0; b < 4; b++) begin
        bit act, pre;
        act = (c == 3) && (bk == b);
        pre = (c == 7) && (ap || bk == b);
        m_act[b] = act ? 1 : sat(m_act[b]);
        if (act) begin
          m_st[b] = 1; m_trp[b] = sat(m_trp[b]);
        end else if (pre && m_st[b] != 0) begin
          m_st[b] = 0; m_trp[b] = 1;
        end else if (c == 6 && m_st[b] == 2) begin
          m_st[b] = 0; m_trp[b] = 1;
        end else if (col && bk == b && ap && m_st[b] == 1) begin
          if (blv == 1) begin m_st[b] = 0; m_trp[b] = 0; end
          else begin m_st[b] = 2; m_rem[b] = blv - 2; m_trp[b] = sat(m_trp[b]); end
        end else if (m_st[b] == 2) begin
          if (m_rem[b] == 0) begin m_st[b] = 0; m_trp[b] = 0; end
          else begin m_rem[b]--; m_trp[b] = sat(m_trp[b]); end
        end else begin
          m_trp[b] = sat(m_trp[b]);
        end
      end
      if (c == 1) m_quiet = 2; else if (m_quiet > 0) m_quiet--;
      m_ref = (c == 2) ? 1 : m_ref + 1;
      e_flags = e;
      e_sticky = (clr ? 9'd0 : e_sticky) | e;
      e_code = 0;
      for (int i = 8; i >= 0; i--) if (e[i]) e_code = i + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 9; i++) chk(int'(flags[i]), int'(e_flags[i]), rq_of(i), $sformatf("flag %0d vs model", i));
      chk(int'(code), e_code, "R11", "code vs model");
      chk(int'(sticky), int'(e_sticky), "R11", "sticky vs model");
    end
  end

  task automatic issue(input logic [3:0] p, input int b, input int a);
    pins = p; bank = 2'(b); addr = 12'(a);
    @(negedge clk);
    pins = P_NOP; bank = '0; addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    chk(int'(flags), 0, "R11", "flags after reset");
    chk(int'(code), 0, "R11", "code after reset");
    chk(int'(sticky), 0, "R11", "sticky after reset");
    idle(1);
    issue(P_REF, 0, 0);            chk(int'(flags[1]), 0, "R2", "refresh all idle");
    issue(P_MRS, 0, 0);            chk(int'(flags[1]), 0, "R2", "mode-set all idle");
    issue(P_ACT, 0, 0);            chk(int'(flags[0]), 1, "R3", "activate right after mode-set");
    idle(1);
    issue(P_ACT, 1, 0);            chk(int'(flags[5]), 0, "R7", "tRRD gap equal");
    issue(P_ACT, 2, 0);            chk(int'(flags[5]), 1, "R7", "tRRD gap short");
    issue(P_RD, 2, 0);             chk(int'(flags[4]), 1, "R7", "tRCD gap short");
    issue(P_RD, 1, 0);             chk(int'(flags[4]), 0, "R7", "tRCD gap equal");
    issue(P_WR, 1, 0);             chk(int'(code), 0, "R6", "column to column gap 1");
    issue(P_MRS, 0, 0);            chk(int'(flags[1]), 1, "R2", "mode-set with open banks");
    idle(2);
    issue(P_PRE, 3, AP);           chk(int'(code), 0, "R6", "precharge all");
    issue(P_RD, 2, 0);             chk(int'(flags[3]), 1, "R6", "bank closed by precharge all");
    issue(P_ACT, 0, 0);            chk(int'(flags[7]), 1, "R5", "tRP after precharge short");
    idle(3);
    issue({1'b1, P_ACT[2:0]}, 3, 0); chk(int'(code), 0, "R1", "deselected activate");
    issue(P_RD, 3, 0);             chk(int'(flags[3]), 1, "R1", "deselected activate left bank idle");
    issue(P_ACT, 1, 0);            chk(int'(code), 0, "R7", "legal activate");
    idle(2);
    issue(P_RD, 0, AP);            chk(int'(code), 0, "R4", "read with auto-precharge");
    issue(P_WR, 1, 0);             chk(int'(flags[2]), 1, "R4", "write during burst");
    idle(1);
    issue(P_RD, 1, 0);             chk(int'(flags[2]), 1, "R4", "read in last burst cycle");
    issue(P_RD, 1, 0);             chk(int'(flags[2]), 0, "R4", "read after burst end");
    issue(P_ACT, 0, 0);            chk(int'(flags[7]), 1, "R5", "activate too soon after burst end");
    issue(P_PRE, 0, 0);            chk(int'(flags[3]), 0, "R9", "single precharge to open bank");
    idle(2);
    issue(P_ACT, 0, 0);            chk(int'(flags[7]), 0, "R5", "tRP gap equal");
                                   chk(int'(flags[6]), 1, "R7", "tRC gap short");
    idle(3);
    issue(P_WR, 0, AP);            chk(int'(code), 0, "R8", "write with auto-precharge");
    issue(P_BST, 0, 0);            chk(int'(code), 0, "R8", "burst stop inside burst");
    issue(P_BST, 0, 0);            chk(int'(code), 0, "R8", "burst stop with no burst");
    issue(P_ACT, 2, 0);            chk(int'(code), 0, "R7", "activate bank 2");
    cfg_bl = 2'd0;
    idle(2);
    issue(P_RD, 1, AP);            chk(int'(code), 0, "R12", "length-1 auto-precharge read");
    issue(P_RD, 2, 0);             chk(int'(flags[2]), 0, "R12", "no window at length 1");
    cfg_bl = 2'd3;
    issue(P_RD, 2, AP);
    idle(6);
    issue(P_RD, 2, 0);             chk(int'(flags[2]), 1, "R12", "length 8 seventh cycle");
    issue(P_RD, 2, 0);             chk(int'(flags[2]), 0, "R12", "length 8 burst over");
    cfg_bl = 2'd2;
    issue(P_PRE, 3, 0);            chk(int'(flags[3]), 1, "R9", "single precharge to idle bank");
    issue(P_ACT, 3, 0);            chk(int'(flags[3]), 0, "R9", "activate idle bank");
    issue(P_ACT, 3, 0);            chk(int'(flags[3]), 1, "R9", "activate open bank");
    issue(P_MRS, 0, 0);
    issue(P_MRS, 0, 0);            chk(int'(code), 1, "R11", "priority of quiet over not-idle");
                                   chk(int'(flags[1]), 1, "R11", "both flags raised");
    chk(int'(sticky != 0), 1, "R11", "sticky holds errors");
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(int'(sticky), 0, "R11", "sticky after clear");
    idle(2);
    issue(P_PRE, 0, AP);
    issue(P_REF, 0, 0);            chk(int'(flags[1]), 0, "R10", "refresh all idle");
    begin
      int n;
      n = 0;
      while (n < LIMIT + 100 && !flags[8]) begin
        @(negedge clk);
        n++;
      end
      chk(n, LIMIT, "R10", "cycles to late refresh flag");
    end
    idle(2);
    chk(int'(flags[8]), 0, "R10", "late flag is one pulse");
    finish_run();
  end

endmodule